// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block sits between an instruction decoder and a banked register file. It takes the 7-bit file offset carried in an instruction, two bank-select bits, and an 8-bit pointer with its own high bank bit. From these it works out which physical location the access lands on. Offset 00h in any bank means the access is indirect. In that case the location comes from the pointer instead of the bank bits and the instruction offset.

The 9-bit physical address is split into a bank (top two bits) and an offset inside the bank. Offsets 00h to 1Fh form the special-register area, and 20h to 7Fh hold general-purpose RAM.

- A few busy special registers answer in every bank.
- Some others answer in pairs of banks.
- The top sixteen RAM bytes are common to all banks.

Every mirrored alias is folded onto one register ID or one RAM index, so the storage behind the mapper holds each copy once.

Results come out one clock after the request. They include the RAM index, a special-register select with its ID, a valid flag, and write enables and a read-zero flag that are already qualified. Unimplemented locations raise no select, block writes, and tell the reader to return zero.

Top module: `bfm_mapper`

## Requirements
- R1: Reset is synchronous and active high. Every output is registered and appears one cycle after `acc_req`. Each output is zero after reset and in any cycle that follows a cycle with `acc_req` low.
- R2: When `acc_off` is not 00h, `out_phys` equals `{bank_sel, acc_off}` and `out_ind` is 0.
- R3: When `acc_off` is 00h, the access is indirect. `out_ind` is 1 and `out_phys` equals `{ptr_hi, ptr_val}`.
- R4: An indirect access whose pointer lands on offset 00h of any bank (`ptr_val[6:0]` = 0) is unimplemented, so `loc_ok` is 0.
- R5: For every request exactly one of these holds: `sfr_sel`, `ram_sel`, or `loc_ok` low. `sfr_sel` can only be set for offsets below 20h, and `ram_sel` only for offsets 20h and above. Here the offset is `out_phys[6:0]` and the bank is `out_phys[8:7]`.
- R6: Offsets 02h, 03h, 04h, 0Ah and 0Bh are special registers in all four banks, and `sfr_id` equals the offset.
- R7: Offsets 01h and 06h are special registers shared by banks 0/2 and by banks 1/3. For these, `sfr_id` equals bank[0]·32 + offset.
- R8: The remaining special-register offsets are implemented only in these places:
  - bank 0, offsets 05h–1Fh, where `sfr_id` equals the offset;
  - bank 1, offsets 05h–0Fh, where `sfr_id` equals 32 + offset.

  Any other special-register offset in banks 1–3 is unimplemented.
- R9: Offsets 70h–7Fh are common RAM in every bank, with `ram_idx` = offset − 32. Offsets 20h–6Fh are mapped as follows:
  - bank 0: `ram_idx` = offset − 32;
  - bank 1: `ram_idx` = offset + 64;
  - banks 2 and 3: unimplemented.
- R10: `ram_we` is high only when the request was a write (`acc_wr`) that hit RAM, and `sfr_we` likewise only for a write that hit a special register. `rd_zero` is high only when the request was a read of an unimplemented location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access request this cycle |
| acc_wr | input | 1 | Request is a write (0 = read) |
| acc_off | input | 7 | File offset from the instruction |
| bank_sel | input | 2 | Bank-select bits for direct access |
| ptr_val | input | 8 | Pointer register for indirect access |
| ptr_hi | input | 1 | High bank bit for indirect access |
| out_vld | output | 1 | Result valid (request seen last cycle) |
| out_ind | output | 1 | Access resolved through the pointer |
| out_phys | output | 9 | Resolved physical address {bank, offset} |
| sfr_sel | output | 1 | Access hits a special register |
| sfr_id | output | 6 | Folded special-register ID |
| ram_sel | output | 1 | Access hits general-purpose RAM |
| ram_idx | output | 8 | Folded RAM index, 0 to 175 |
| loc_ok | output | 1 | Location is implemented |
| sfr_we | output | 1 | Qualified special-register write |
| ram_we | output | 1 | Qualified RAM write |
| rd_zero | output | 1 | Read of an unimplemented location, return zero |

## Verification
The hardest cases to reach from the ports are indirect accesses that land in the sparse parts of the map. These include a pointer that refers back to offset 00h of some bank, and a pointer with `ptr_hi` set that reaches the gaps in banks 2 and 3. Uniform random offsets rarely produce offset 00h, and random pointers land on a 00h offset only once in 128 tries. The stimulus therefore biases a quarter of the random accesses toward offset 00h, and clears the low pointer bits on a share of those. Directed accesses also hit each mirrored offset in all four banks and the edges of each RAM window.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    localparam int OFF_W       = 7;
    localparam int BANK_W      = 2;
    localparam int PTR_W       = 8;
    localparam int PHYS_W      = BANK_W + OFF_W;
    localparam int BANK_SPAN   = 1 << OFF_W;
    localparam int SFR_TOP     = 32;
    localparam int SFR_OFF_W   = $clog2(SFR_TOP);
    localparam int SFR_ID_W    = SFR_OFF_W + 1;
    localparam int BANK1_SFR_END = 16;
    localparam int COMMON_BASE = 112;
    localparam int BANK0_RAM   = BANK_SPAN - SFR_TOP;
    localparam int BANK1_RAM   = COMMON_BASE - SFR_TOP;
    localparam int RAM_DEPTH   = BANK0_RAM + BANK1_RAM;
    localparam int IDX_W       = $clog2(RAM_DEPTH);

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [PHYS_W-1:0] phys_t;

    typedef struct packed {
        logic                hit;
        logic [SFR_ID_W-1:0] id;
    } sfr_dec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } ram_dec_t;

    typedef struct packed {
        logic  ind;
        phys_t phys;
        bank_t bank;
        off_t  off;
    } loc_t;

    // Special registers answering in every bank.
    function automatic logic is_global_mirror(input logic [SFR_OFF_W-1:0] o);
        return (o == 5'h02) || (o == 5'h03) || (o == 5'h04) ||
               (o == 5'h0A) || (o == 5'h0B);
    endfunction

    // Special registers shared between banks that differ only in bank[1].
    function automatic logic is_pair_mirror(input logic [SFR_OFF_W-1:0] o);
        return (o == 5'h01) || (o == 5'h06);
    endfunction

endpackage

// File: rtl/bfm_resolve.sv
module bfm_resolve
    import bfm_pkg::*;
(
    input  off_t                   acc_off,
    input  bank_t                  bank_sel,
    input  logic [PTR_W-1:0]       ptr_val,
    input  logic                   ptr_hi,
    output loc_t                   loc
);
    always_comb begin
        loc = '0;
        loc.ind  = (acc_off == '0);
        loc.phys = loc.ind ? {ptr_hi, ptr_val} : {bank_sel, acc_off};
        loc.bank = loc.phys[PHYS_W-1 -: BANK_W];
        loc.off  = loc.phys[OFF_W-1:0];
    end
endmodule

// File: rtl/bfm_sfr_decode.sv
module bfm_sfr_decode
    import bfm_pkg::*;
(
    input  bank_t    bank,
    input  off_t     off,
    output sfr_dec_t dec
);
    logic [SFR_OFF_W-1:0] o5;
    logic                 in_area;

    assign o5      = off[SFR_OFF_W-1:0];
    assign in_area = (off < OFF_W'(SFR_TOP)) && (off != '0);

    always_comb begin
        dec = '0;
        if (in_area) begin
            if (is_global_mirror(o5)) begin
                dec.hit = 1'b1;
                dec.id  = {1'b0, o5};
            end else if (is_pair_mirror(o5)) begin
                dec.hit = 1'b1;
                dec.id  = {bank[0], o5};
            end else if (bank == BANK_W'(0)) begin
                dec.hit = 1'b1;
                dec.id  = {1'b0, o5};
            end else if ((bank == BANK_W'(1)) && (off < OFF_W'(BANK1_SFR_END))) begin
                dec.hit = 1'b1;
                dec.id  = {1'b1, o5};
            end
        end
    end
endmodule

// File: rtl/bfm_ram_decode.sv
module bfm_ram_decode
    import bfm_pkg::*;
(
    input  bank_t    bank,
    input  off_t     off,
    output ram_dec_t dec
);
    logic [IDX_W-1:0] rel;

    assign rel = IDX_W'(off) - IDX_W'(SFR_TOP);

    always_comb begin
        dec = '0;
        if (off >= OFF_W'(SFR_TOP)) begin
            if (off >= OFF_W'(COMMON_BASE)) begin
                dec.hit = 1'b1;
                dec.idx = rel;
            end else if (bank == BANK_W'(0)) begin
                dec.hit = 1'b1;
                dec.idx = rel;
            end else if (bank == BANK_W'(1)) begin
                dec.hit = 1'b1;
                dec.idx = rel + IDX_W'(BANK0_RAM);
            end
        end
    end
endmodule

// File: rtl/bfm_mapper.sv
module bfm_mapper
    import bfm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_req,
    input  logic                 acc_wr,
    input  logic [OFF_W-1:0]     acc_off,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [PTR_W-1:0]     ptr_val,
    input  logic                 ptr_hi,
    output logic                 out_vld,
    output logic                 out_ind,
    output logic [PHYS_W-1:0]    out_phys,
    output logic                 sfr_sel,
    output logic [SFR_ID_W-1:0]  sfr_id,
    output logic                 ram_sel,
    output logic [IDX_W-1:0]     ram_idx,
    output logic                 loc_ok,
    output logic                 sfr_we,
    output logic                 ram_we,
    output logic                 rd_zero
);
    loc_t     loc;
    sfr_dec_t sdec;
    ram_dec_t rdec;
    logic     hit;

    bfm_resolve u_resolve (
        .acc_off (acc_off),
        .bank_sel(bank_sel),
        .ptr_val (ptr_val),
        .ptr_hi  (ptr_hi),
        .loc     (loc)
    );

    bfm_sfr_decode u_sfr (
        .bank(loc.bank),
        .off (loc.off),
        .dec (sdec)
    );

    bfm_ram_decode u_ram (
        .bank(loc.bank),
        .off (loc.off),
        .dec (rdec)
    );

    assign hit = sdec.hit | rdec.hit;

    always_ff @(posedge clk) begin
        if (rst || !acc_req) begin
            out_vld  <= 1'b0;
            out_ind  <= 1'b0;
            out_phys <= '0;
            sfr_sel  <= 1'b0;
            sfr_id   <= '0;
            ram_sel  <= 1'b0;
            ram_idx  <= '0;
            loc_ok   <= 1'b0;
            sfr_we   <= 1'b0;
            ram_we   <= 1'b0;
            rd_zero  <= 1'b0;
        end else begin
            out_vld  <= 1'b1;
            out_ind  <= loc.ind;
            out_phys <= loc.phys;
            sfr_sel  <= sdec.hit;
            sfr_id   <= sdec.id;
            ram_sel  <= rdec.hit;
            ram_idx  <= rdec.idx;
            loc_ok   <= hit;
            sfr_we   <= acc_wr & sdec.hit;
            ram_we   <= acc_wr & rdec.hit;
            rd_zero  <= ~acc_wr & ~hit;
        end
    end

    assert_vld_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> out_vld);

    assert_idle_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> (!out_vld && !sfr_sel && !ram_sel && !ram_we && !sfr_we && !rd_zero));

    assert_direct_phys_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_off != '0) |=> (out_phys == {$past(bank_sel), $past(acc_off)}) && !out_ind);

    assert_indirect_phys_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_off == '0) |=> (out_phys == {$past(ptr_hi), $past(ptr_val)}) && out_ind);

    assert_self_ref_invalid_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_off == '0 && ptr_val[OFF_W-1:0] == '0) |=> !loc_ok);

    assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones({sfr_sel, ram_sel, !loc_ok}) == 1));

    assert_status_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_off == 7'h03) |=> (sfr_sel && sfr_id == SFR_ID_W'(3)));

    assert_ram_bound_R9: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> (ram_idx < IDX_W'(RAM_DEPTH)));

    assert_write_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (ram_we || sfr_we) |-> (loc_ok && !rd_zero && $onehot0({ram_we, sfr_we})));

    assert_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        rd_zero |-> (!loc_ok && !ram_we && !sfr_we));

endmodule

// File: tb/tb_bfm_mapper.sv
module tb_bfm_mapper;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_req, acc_wr, ptr_hi;
    logic [6:0] acc_off;
    logic [1:0] bank_sel;
    logic [7:0] ptr_val;
    logic       out_vld, out_ind, sfr_sel, ram_sel, loc_ok, sfr_we, ram_we, rd_zero;
    logic [8:0] out_phys;
    logic [5:0] sfr_id;
    logic [7:0] ram_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bfm_mapper dut (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_off(acc_off), .bank_sel(bank_sel), .ptr_val(ptr_val), .ptr_hi(ptr_hi),
        .out_vld(out_vld), .out_ind(out_ind), .out_phys(out_phys),
        .sfr_sel(sfr_sel), .sfr_id(sfr_id), .ram_sel(ram_sel), .ram_idx(ram_idx),
        .loc_ok(loc_ok), .sfr_we(sfr_we), .ram_we(ram_we), .rd_zero(rd_zero)
    );

    typedef struct {
        bit vld, ind, sfr, ram, ok, swe, rwe, rz;
        int phys, id, idx;
    } exp_t;

    function automatic exp_t ref_map(bit req, bit wr, int off, int bank, int ptr, bit hi);
        exp_t e;
        int b, o;
        e = '{default: 0};
        if (!req) return e;
        e.vld = 1;
        if (off == 0) begin
            e.ind  = 1;
            e.phys = hi * 256 + ptr;
        end else begin
            e.phys = bank * 128 + off;
        end
        b = e.phys / 128;
        o = e.phys % 128;
        if (o == 0) begin
            // R4: pointer back onto an indirect slot
        end else if (o < 32) begin
            if (o == 2 || o == 3 || o == 4 || o == 10 || o == 11) begin
                e.sfr = 1; e.id = o;
            end else if (o == 1 || o == 6) begin
                e.sfr = 1; e.id = (b % 2) * 32 + o;
            end else if (b == 0) begin
                e.sfr = 1; e.id = o;
            end else if (b == 1 && o < 16) begin
                e.sfr = 1; e.id = 32 + o;
            end
        end else if (o >= 112) begin
            e.ram = 1; e.idx = o - 32;
        end else if (b == 0) begin
            e.ram = 1; e.idx = o - 32;
        end else if (b == 1) begin
            e.ram = 1; e.idx = o + 64;
        end
        e.ok  = e.sfr | e.ram;
        e.swe = wr & e.sfr;
        e.rwe = wr & e.ram;
        e.rz  = !wr & !e.ok;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (off=%0h bank=%0d ptr=%0h hi=%0d)",
                     tag, act, exp, acc_off, bank_sel, ptr_val, ptr_hi);
        end
    endtask

    task automatic compare(exp_t e);
        chk(out_vld == e.vld, "R1 out_vld", out_vld, e.vld);
        chk(out_ind == e.ind, "R3 out_ind", out_ind, e.ind);
        chk(int'(out_phys) == e.phys, e.ind ? "R3 out_phys" : "R2 out_phys", out_phys, e.phys);
        chk(loc_ok == e.ok, e.ind ? "R4 loc_ok" : "R5 loc_ok", loc_ok, e.ok);
        chk(sfr_sel == e.sfr, "R5 sfr_sel", sfr_sel, e.sfr);
        chk(ram_sel == e.ram, "R5 ram_sel", ram_sel, e.ram);
        if (e.sfr) chk(int'(sfr_id) == e.id, "R6/R7/R8 sfr_id", sfr_id, e.id);
        if (e.ram) chk(int'(ram_idx) == e.idx, "R9 ram_idx", ram_idx, e.idx);
        chk(sfr_we == e.swe, "R10 sfr_we", sfr_we, e.swe);
        chk(ram_we == e.rwe, "R10 ram_we", ram_we, e.rwe);
        chk(rd_zero == e.rz, "R10 rd_zero", rd_zero, e.rz);
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic access(bit req, bit wr, int off, int bank, int ptr, bit hi);
        exp_t e;
        acc_req  = req;
        acc_wr   = wr;
        acc_off  = 7'(off);
        bank_sel = 2'(bank);
        ptr_val  = 8'(ptr);
        ptr_hi   = hi;
        e = ref_map(req, wr, off, bank, ptr, hi);
        @(negedge clk);
        compare(e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; acc_req = 1'b1; acc_wr = 1'b1; acc_off = 7'h03;
        bank_sel = 2'd0; ptr_val = 8'h00; ptr_hi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with a request pending
        chk(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
        chk(ram_we == 1'b0 && sfr_we == 1'b0, "R1 reset write enables", {ram_we, sfr_we}, 0);
        chk(loc_ok == 1'b0 && rd_zero == 1'b0, "R1 reset flags", {loc_ok, rd_zero}, 0);
        rst = 1'b0;
        acc_req = 1'b0;
        @(negedge clk);

        // R1: idle cycle
        access(0, 1, 7'h20, 0, 0, 0);
        // R6: global mirrors in all banks
        for (int b = 0; b < 4; b++) access(1, 0, 7'h03, b, 0, 0);
        for (int b = 0; b < 4; b++) access(1, 1, 7'h0B, b, 0, 0);
        // R7: pair mirrors
        for (int b = 0; b < 4; b++) access(1, 0, 7'h01, b, 0, 0);
        for (int b = 0; b < 4; b++) access(1, 1, 7'h06, b, 0, 0);
        // R8: private edges
        access(1, 1, 7'h1F, 0, 0, 0);
        access(1, 0, 7'h0F, 1, 0, 0);
        access(1, 0, 7'h10, 1, 0, 0);
        access(1, 1, 7'h05, 2, 0, 0);
        access(1, 0, 7'h1F, 3, 0, 0);
        // R9: RAM windows and common area
        access(1, 1, 7'h20, 0, 0, 0);
        access(1, 0, 7'h7F, 0, 0, 0);
        access(1, 1, 7'h20, 1, 0, 0);
        access(1, 0, 7'h6F, 1, 0, 0);
        access(1, 0, 7'h6F, 2, 0, 0);
        access(1, 1, 7'h70, 3, 0, 0);
        access(1, 0, 7'h7F, 2, 0, 0);
        // R3/R4: indirect, including self reference
        access(1, 0, 7'h00, 2, 8'h03, 1);
        access(1, 1, 7'h00, 0, 8'h80, 1);
        access(1, 0, 7'h00, 3, 8'h00, 0);
        access(1, 1, 7'h00, 1, 8'hA5, 0);
        access(1, 0, 7'h00, 0, 8'hF0, 1);
        access(0, 0, 7'h00, 0, 8'h00, 0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int off, ptr;
            off = int'($urandom_range(0, 127));
            if ($urandom_range(0, 3) == 0) off = 0;
            ptr = int'($urandom_range(0, 255));
            if ($urandom_range(0, 7) == 0) ptr = ptr & 8'h80;
            access($urandom_range(0, 9) != 0, 1'($urandom_range(0, 1)), off,
                   int'($urandom_range(0, 3)), ptr, 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule